// File: doc/BRIEF.md
# Triggered Shadow Register Bank

This block is the control register file of a serially controlled RF front-end slave. An external bus decoder turns serial frames into single-cycle write and read strobes with an 8-bit address and 8-bit data. The block stores the values, steers writes and drives the live configuration to the analog side.

Each configuration register has a shadow copy and is tied to one or more of three triggers. While at least one of its triggers is enabled, a write lands in the shadow copy, and a later trigger bit commits it. When every trigger tied to a register is masked, writes go straight to the live register. A control register holds the power mode, the mask bits, self-clearing trigger bits and a self-clearing software reset. Two read-only identity bytes complete the map.

Top module: `trig_cfg_bank`

## Requirements
- R1: After reset, `lowpwr_o` is 1 and `cfg_o` is all zero. The control register at 0x1C reads 0x80, the product byte at 0x1D reads 0x4C and the maker byte at 0x1E reads 0xC6.
- R2: Bit 7 of a write to 0x1C sets the power mode, and `lowpwr_o` shows it from the write edge onward (1 = isolation, 0 = active).
- R3: Configuration registers sit at 0x00, 0x01 and 0x02. They are tied to trigger 0, trigger 1, and triggers 1 and 2 respectively. While any tied trigger is unmasked, a write reaches only the shadow copy, and the live value and its readback stay unchanged.
- R4: Writing 1 to trigger bit N (bit N of 0x1C, N = 0..2) copies the shadow into the live register of every configuration register tied to an unmasked trigger N. All such copies happen at the same edge.
- R5: Mask bit N (bit 3+N of 0x1C) disables trigger N, so a set trigger bit N is ignored. When all triggers of a register are masked, a write goes to its live value and leaves its shadow unchanged.
- R6: The register at 0x02 takes direct writes only when masks 1 and 2 are both set. With just one of them set, writes go to the shadow and the unmasked trigger commits them.
- R7: In a single write to 0x1C, the new mask bits are applied before the trigger bits in the same byte are evaluated.
- R8: Reading 0x1C returns the power mode and the mask bits. Bits 6 and 2:0 always read as 0.
- R9: Writing 1 to bit 6 of 0x1C returns the power mode, masks, live values and shadows to their defaults at that edge. This overrides any trigger or power bits in the same byte.
- R10: Writes to 0x1D and 0x1E never change the values read from them.
- R11: Any other address reads as 0x00, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| lowpwr_o | output | 1 | Power mode, 1 = isolation |
| cfg_o | output | 24 | Live configuration values, register i at bits [8i+7:8i] |

## Verification
A write updates `lowpwr_o` and `cfg_o` at the clock edge that samples the strobe. That covers direct writes, trigger commits and software reset, so these outputs are correct one edge after the write is presented. Read data is registered and appears on `rdata` at the edge that samples `rd_en`, and it reflects the state before any write in that same cycle. The bench drives every strobe on the falling edge and samples at the next falling edge. Each result is therefore checked half a period after the edge that produced it, and reads are never overlapped with writes.

// File: rtl/trig_cfg_pkg.sv
package trig_cfg_pkg;
  localparam int DW    = 8;
  localparam int NTRIG = 3;

  // layout of the control byte; bit positions are decoded by software
  typedef struct packed {
    logic             pwr;
    logic             srst;
    logic [NTRIG-1:0] mask;
    logic [NTRIG-1:0] trig;
  } ctrl_byte_t;
endpackage

// File: rtl/trig_cfg_ctrl.sv
module trig_cfg_ctrl
  import trig_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_ctrl,
  input  logic [DW-1:0]    wdata,
  output logic             lowpwr_o,
  output logic [NTRIG-1:0] mask_o,
  output logic [NTRIG-1:0] fire_o,
  output logic             clear_o
);
  ctrl_byte_t wb;
  assign wb = ctrl_byte_t'(wdata);

  // software reset rides on the same edge as the write
  assign clear_o = rst | (wr_ctrl & wb.srst);
  // incoming mask gates incoming triggers: mask first, then trigger
  assign fire_o  = (wr_ctrl && !wb.srst) ? (wb.trig & ~wb.mask) : '0;

  always_ff @(posedge clk) begin
    if (clear_o) begin
      lowpwr_o <= 1'b1;
      mask_o   <= '0;
    end else if (wr_ctrl) begin
      lowpwr_o <= wb.pwr;
      mask_o   <= wb.mask;
    end
  end

  // R9
  srst_default_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && wdata[6]) |=> (lowpwr_o && mask_o == '0));

  // R2
  pwr_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && !wdata[6]) |=> (lowpwr_o == $past(wdata[7])));
endmodule

// File: rtl/trig_cfg_slot.sv
module trig_cfg_slot
  import trig_cfg_pkg::*;
#(
  parameter logic [NTRIG-1:0] MAP = 3'b001
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             wr_hit,
  input  logic [DW-1:0]    wdata,
  input  logic [NTRIG-1:0] mask,
  input  logic [NTRIG-1:0] fire,
  output logic [DW-1:0]    live
);
  logic [DW-1:0] shadow;
  logic          direct;
  logic          commit;

  assign direct = ((MAP & ~mask) == '0);
  assign commit = |(fire & MAP);

  always_ff @(posedge clk) begin
    if (clear) begin
      shadow <= '0;
      live   <= '0;
    end else begin
      if (wr_hit) begin
        if (direct) live   <= wdata;
        else        shadow <= wdata;
      end
      if (commit) live <= shadow;
    end
  end

  // R5
  direct_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (!clear && wr_hit && direct) |=> (live == $past(wdata)));

  // R3
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clear && wr_hit && !direct && !commit) |=> $stable(live));

  // R4
  commit_chk: assert property (@(posedge clk) disable iff (rst)
    (!clear && commit) |=> (live == $past(shadow)));

  // R9
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> (live == '0 && shadow == '0));
endmodule

// File: rtl/trig_cfg_rdmux.sv
module trig_cfg_rdmux
  import trig_cfg_pkg::*;
#(
  parameter int          NCFG      = 3,
  parameter logic [7:0]  CFG_BASE  = 8'h00,
  parameter logic [7:0]  CTRL_ADDR = 8'h1C,
  parameter logic [7:0]  PID_ADDR  = 8'h1D,
  parameter logic [7:0]  MID_ADDR  = 8'h1E,
  parameter logic [DW-1:0] PID_VAL = 8'h4C,
  parameter logic [DW-1:0] MID_VAL = 8'hC6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  logic [7:0]         addr,
  input  logic [DW-1:0]      ctrl_view,
  input  logic [NCFG*DW-1:0] live_flat,
  output logic [DW-1:0]      rdata
);
  logic [DW-1:0] sel;
  logic          hit;

  always_comb begin
    sel = '0;
    hit = 1'b1;
    if (addr == CTRL_ADDR)     sel = ctrl_view;
    else if (addr == PID_ADDR) sel = PID_VAL;
    else if (addr == MID_ADDR) sel = MID_VAL;
    else begin
      hit = 1'b0;
      for (int i = 0; i < NCFG; i++) begin
        if (addr == 8'(int'(CFG_BASE) + i)) begin
          sel = live_flat[i*DW +: DW];
          hit = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= sel;
  end

  // R11
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !hit) |=> (rdata == '0));

  // R10
  pid_const_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == PID_ADDR) |=> (rdata == PID_VAL));
endmodule

// File: rtl/trig_cfg_bank.sv
module trig_cfg_bank
  import trig_cfg_pkg::*;
#(
  parameter int            NCFG      = 3,
  parameter logic [7:0]    CFG_BASE  = 8'h00,
  parameter logic [7:0]    CTRL_ADDR = 8'h1C,
  parameter logic [7:0]    PID_ADDR  = 8'h1D,
  parameter logic [7:0]    MID_ADDR  = 8'h1E,
  parameter logic [DW-1:0] PID_VAL   = 8'h4C,
  parameter logic [DW-1:0] MID_VAL   = 8'hC6,
  // trigger association per register, register i at bits [i*NTRIG +: NTRIG]
  parameter logic [NCFG*NTRIG-1:0] TRIG_MAP = 9'b110_010_001
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [7:0]         addr,
  input  logic [DW-1:0]      wdata,
  output logic [DW-1:0]      rdata,
  output logic               lowpwr_o,
  output logic [NCFG*DW-1:0] cfg_o
);
  logic             wr_ctrl;
  logic [NTRIG-1:0] mask;
  logic [NTRIG-1:0] fire;
  logic             clear;
  logic [DW-1:0]    ctrl_view;
  ctrl_byte_t       view_s;

  assign wr_ctrl = wr_en && (addr == CTRL_ADDR);

  trig_cfg_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wr_ctrl  (wr_ctrl),
    .wdata    (wdata),
    .lowpwr_o (lowpwr_o),
    .mask_o   (mask),
    .fire_o   (fire),
    .clear_o  (clear)
  );

  genvar g;
  generate
    for (g = 0; g < NCFG; g++) begin : g_slot
      logic hit_w;
      assign hit_w = wr_en && (addr == 8'(int'(CFG_BASE) + g));
      trig_cfg_slot #(.MAP(TRIG_MAP[g*NTRIG +: NTRIG])) u_slot (
        .clk    (clk),
        .rst    (rst),
        .clear  (clear),
        .wr_hit (hit_w),
        .wdata  (wdata),
        .mask   (mask),
        .fire   (fire),
        .live   (cfg_o[g*DW +: DW])
      );
    end
  endgenerate

  always_comb begin
    view_s      = '0;
    view_s.pwr  = lowpwr_o;
    view_s.mask = mask;
  end
  assign ctrl_view = DW'(view_s);

  trig_cfg_rdmux #(
    .NCFG(NCFG), .CFG_BASE(CFG_BASE), .CTRL_ADDR(CTRL_ADDR),
    .PID_ADDR(PID_ADDR), .MID_ADDR(MID_ADDR),
    .PID_VAL(PID_VAL), .MID_VAL(MID_VAL)
  ) u_rdmux (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (rd_en),
    .addr      (addr),
    .ctrl_view (ctrl_view),
    .live_flat (cfg_o),
    .rdata     (rdata)
  );

  // R11
  stray_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr != CTRL_ADDR && addr >= 8'(int'(CFG_BASE) + NCFG))
      |=> ($stable(cfg_o) && $stable(lowpwr_o)));
endmodule

// File: tb/trig_cfg_bank_bench.sv
module trig_cfg_bank_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        lowpwr_o;
  logic [23:0] cfg_o;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #2 clk = ~clk;

  trig_cfg_bank u_trig_cfg_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .lowpwr_o(lowpwr_o), .cfg_o(cfg_o)
  );

  // {req[3:0], op[1:0] (0 write, 1 read-check), addr, data, expected}
  localparam logic [29:0] VEC [48] = '{
    {4'd1, 2'd1, 8'h1C, 8'h00, 8'h80},  // R1
    {4'd1, 2'd1, 8'h1D, 8'h00, 8'h4C},  // R1
    {4'd1, 2'd1, 8'h1E, 8'h00, 8'hC6},  // R1
    {4'd3, 2'd0, 8'h00, 8'h11, 8'h00},  // R3 shadow write
    {4'd3, 2'd1, 8'h00, 8'h00, 8'h00},  // R3
    {4'd4, 2'd0, 8'h1C, 8'h01, 8'h00},  // R4 trigger 0
    {4'd4, 2'd1, 8'h00, 8'h00, 8'h11},  // R4
    {4'd8, 2'd1, 8'h1C, 8'h00, 8'h00},  // R8 trigger reads 0
    {4'd3, 2'd0, 8'h01, 8'h22, 8'h00},  // R3
    {4'd3, 2'd0, 8'h02, 8'h33, 8'h00},  // R3
    {4'd3, 2'd1, 8'h01, 8'h00, 8'h00},  // R3
    {4'd3, 2'd1, 8'h02, 8'h00, 8'h00},  // R3
    {4'd4, 2'd0, 8'h1C, 8'h02, 8'h00},  // R4 trigger 1 hits two regs
    {4'd4, 2'd1, 8'h01, 8'h00, 8'h22},  // R4
    {4'd6, 2'd1, 8'h02, 8'h00, 8'h33},  // R6
    {4'd5, 2'd0, 8'h1C, 8'h10, 8'h00},  // R5 mask 1
    {4'd8, 2'd1, 8'h1C, 8'h00, 8'h10},  // R8
    {4'd5, 2'd0, 8'h01, 8'h44, 8'h00},  // R5 direct
    {4'd5, 2'd1, 8'h01, 8'h00, 8'h44},  // R5
    {4'd6, 2'd0, 8'h02, 8'h55, 8'h00},  // R6 still shadowed
    {4'd6, 2'd1, 8'h02, 8'h00, 8'h33},  // R6
    {4'd6, 2'd0, 8'h1C, 8'h14, 8'h00},  // R6 trigger 2
    {4'd6, 2'd1, 8'h02, 8'h00, 8'h55},  // R6
    {4'd6, 2'd1, 8'h01, 8'h00, 8'h44},  // R6
    {4'd6, 2'd0, 8'h1C, 8'h30, 8'h00},  // R6 mask 1 and 2
    {4'd6, 2'd0, 8'h02, 8'h66, 8'h00},  // R6 direct
    {4'd6, 2'd1, 8'h02, 8'h00, 8'h66},  // R6
    {4'd5, 2'd0, 8'h1C, 8'h32, 8'h00},  // R5 masked trigger 1
    {4'd5, 2'd1, 8'h01, 8'h00, 8'h44},  // R5
    {4'd7, 2'd0, 8'h1C, 8'h00, 8'h00},  // R7
    {4'd7, 2'd0, 8'h00, 8'h77, 8'h00},  // R7
    {4'd7, 2'd0, 8'h1C, 8'h09, 8'h00},  // R7 mask and trigger together
    {4'd7, 2'd1, 8'h00, 8'h00, 8'h11},  // R7
    {4'd8, 2'd1, 8'h1C, 8'h00, 8'h08},  // R8
    {4'd5, 2'd0, 8'h00, 8'h88, 8'h00},  // R5
    {4'd5, 2'd1, 8'h00, 8'h00, 8'h88},  // R5
    {4'd7, 2'd0, 8'h1C, 8'h01, 8'h00},  // R7 unmask and trigger
    {4'd7, 2'd1, 8'h00, 8'h00, 8'h77},  // R7 shadow kept by R5
    {4'd10, 2'd0, 8'h1D, 8'hFF, 8'h00}, // R10
    {4'd10, 2'd1, 8'h1D, 8'h00, 8'h4C}, // R10
    {4'd10, 2'd0, 8'h1E, 8'h00, 8'h00}, // R10
    {4'd10, 2'd1, 8'h1E, 8'h00, 8'hC6}, // R10
    {4'd11, 2'd0, 8'h05, 8'hAB, 8'h00}, // R11
    {4'd11, 2'd1, 8'h05, 8'h00, 8'h00}, // R11
    {4'd11, 2'd1, 8'h40, 8'h00, 8'h00}, // R11
    {4'd11, 2'd1, 8'h00, 8'h00, 8'h77}, // R11
    {4'd11, 2'd1, 8'h01, 8'h00, 8'h44}, // R11
    {4'd11, 2'd1, 8'h02, 8'h00, 8'h66}  // R11
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 port reset state
    check("R1", 32'(lowpwr_o), 32'h1);
    check("R1", 32'(cfg_o), 32'h0);

    for (int i = 0; i < 48; i++) begin
      if (VEC[i][25:24] == 2'd0) wr(VEC[i][23:16], VEC[i][15:8]);
      else begin
        rd(VEC[i][23:16], r);
        check($sformatf("R%0d", VEC[i][29:26]), 32'(r), 32'(VEC[i][7:0]));
      end
    end
    // R4 live values visible on the configuration port
    check("R4", 32'(cfg_o), 32'h664477);

    // R2 power mode bit
    wr(8'h1C, 8'h80);
    check("R2", 32'(lowpwr_o), 32'h1);
    wr(8'h1C, 8'h00);
    check("R2", 32'(lowpwr_o), 32'h0);

    // R9 software reset beats triggers and power bit in the same byte
    wr(8'h00, 8'h5A);
    wr(8'h1C, 8'h10);
    wr(8'h1C, 8'h47);
    check("R9", 32'(lowpwr_o), 32'h1);
    check("R9", 32'(cfg_o), 32'h0);
    rd(8'h1C, r);
    check("R9", 32'(r), 32'h80);
    wr(8'h1C, 8'h01);
    rd(8'h00, r);
    check("R9", 32'(r), 32'h00);
    check("R9", 32'(lowpwr_o), 32'h0);

    // R1 hardware reset after traffic
    wr(8'h1C, 8'h08);
    wr(8'h00, 8'h3C);
    check("R5", 32'(cfg_o), 32'h00003C);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1", 32'(cfg_o), 32'h0);
    check("R1", 32'(lowpwr_o), 32'h1);
    rd(8'h1C, r);
    check("R1", 32'(r), 32'h80);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule